// File: doc/BRIEF.md
# Storage Key Protection Unit

This unit keeps one protection key for every 4 KiB block of main storage and rules on each storage request before the memory data path acts on it. A key holds a four-bit lock value, a fetch-guard bit, a referenced bit and a modified bit. A request brings an address, a read/write type, a four-bit access key, the kind of requester (CPU operand, CPU instruction fetch, channel program or measurement block) and two address qualifiers: whether the address went through translation, and whether the translated space is private.

The ruling appears one cycle after the request, together with a valid strobe. A denial is reported on the flag that suits the requester. The unit also produces the write enable that the memory uses. Two override enables relax the checks: one for blocks whose lock value is 9, and one for fetches from the lowest 2 KiB. Granted requests set the referenced bit, and granted writes set the modified bit. A maintenance port lets software write a whole key and read any key back.

Top module: `skp_unit`

## Requirements
- R1: After reset every key is all zero. A maintenance write (`kw_en`) replaces the whole key of block `kw_blk`, and the change shows on the combinational read port (`kr_blk` → `kr_*`) from the next cycle on.
- R2: A request is granted whenever its access key is 0 or equals the block's lock value, whatever the other bits are.
- R3: When the block's fetch-guard bit is 0, fetches pass with any access key. Writes with a non-matching, non-zero key are still denied.
- R4: When the fetch-guard bit is 1, a fetch with a non-matching, non-zero key is denied unless an override applies.
- R5: With `sp_ovr_en` set, a block whose lock value is 9 grants every CPU operand or CPU instruction-fetch request. The override does not apply to channel-program or measurement-block requests.
- R6: With `fp_ovr_en` set, a fetch at an address below 2048 ignores the fetch-guard bit. This does not hold when both `req_xlat` and `req_priv` are 1, or when the requester is the measurement block. The override never excuses a write.
- R7: A denied CPU-operand request (`req_src`=0) raises `rsp_opnd_exc` and no other denial flag.
- R8: An instruction fetch (`req_src`=1) always counts as a fetch, even when `req_store` is 1. A denied instruction fetch raises `rsp_if_supp`, with `rsp_ilc` = 0.
- R9: A denied channel-program request (`req_src`=2) raises `rsp_chan_pchk`. A denied measurement-block request (`req_src`=3) raises `rsp_meas_pchk`.
- R10: `rsp_mem_we` is 1 only for a granted write. A denied write or any fetch leaves it at 0.
- R11: A granted request sets the block's referenced bit, and a granted write also sets its modified bit. A denied request changes neither bit.
- R12: A request in the same cycle as a maintenance write to its block is judged with the old key. The maintenance write wins over the referenced/modified update in that cycle.
- R13: `rsp_valid` and all result flags are registered one cycle after `req_valid`. They are all 0 in the cycle after a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Effective address |
| req_store | input | 1 | 1 = write, 0 = fetch |
| req_key | input | 4 | Access key |
| req_src | input | 2 | 0 operand, 1 instruction fetch, 2 channel, 3 measurement |
| req_xlat | input | 1 | Address was translated |
| req_priv | input | 1 | Private-space qualifier |
| sp_ovr_en | input | 1 | Lock-value-9 override enable |
| fp_ovr_en | input | 1 | Low-address fetch override enable |
| kw_en | input | 1 | Maintenance key write |
| kw_blk | input | ADDR_W-12 | Block to write |
| kw_acc | input | 4 | New lock value |
| kw_fp | input | 1 | New fetch-guard bit |
| kw_ref | input | 1 | New referenced bit |
| kw_chg | input | 1 | New modified bit |
| kr_blk | input | ADDR_W-12 | Block to read |
| kr_acc | output | 4 | Lock value read |
| kr_fp | output | 1 | Fetch-guard bit read |
| kr_ref | output | 1 | Referenced bit read |
| kr_chg | output | 1 | Modified bit read |
| rsp_valid | output | 1 | Result strobe |
| rsp_grant | output | 1 | Request granted |
| rsp_opnd_exc | output | 1 | Operand protection exception |
| rsp_if_supp | output | 1 | Instruction fetch suppressed |
| rsp_ilc | output | 2 | Instruction-length code on suppression |
| rsp_chan_pchk | output | 1 | Channel protection check |
| rsp_meas_pchk | output | 1 | Measurement-block protection check |
| rsp_mem_we | output | 1 | Memory write enable |

## Verification
Several properties are checked by assertions on every cycle:
- At most one denial flag is raised, and a denial always has exactly one flag.
- The write enable never comes with a denial.
- The response strobe follows the request by one cycle.
- A zero key or an unguarded fetch never leads to a denial.
- Granted requests leave the referenced and modified bits set, and maintenance writes land intact.

Other behaviour depends on particular key contents and override settings, and only the bench scenarios show it:
- The lock-value-9 and low-address overrides, including their exclusions and the 2047/2048 boundary.
- Judging with the old key during a colliding maintenance write.
- Denied requests leaving the bits alone.

// File: rtl/skp_pkg.sv
package skp_pkg;

    typedef enum logic [1:0] {
        SRC_OPND   = 2'd0,
        SRC_IFETCH = 2'd1,
        SRC_CHAN   = 2'd2,
        SRC_MEAS   = 2'd3
    } src_e;

    typedef struct packed {
        logic [3:0] acc;
        logic       fp;
        logic       rf;
        logic       ch;
    } skey_t;

    typedef struct packed {
        logic valid;
        logic deny;
        logic store;
        src_e src;
    } verdict_t;

    localparam int          BLK_SHIFT  = 12;
    localparam logic [3:0]  BYPASS_KEY = 4'd9;

    function automatic logic key_fits(input logic [3:0] ak, input logic [3:0] acc);
        return (ak == 4'd0) || (ak == acc);
    endfunction

    function automatic logic is_cpu(input src_e s);
        return (s == SRC_OPND) || (s == SRC_IFETCH);
    endfunction

endpackage

// File: rtl/skp_key_store.sv
module skp_key_store
    import skp_pkg::*;
#(
    parameter int NBLK  = 256,
    parameter int BLK_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BLK_W-1:0] lk_blk,
    output skey_t            lk_key,
    input  logic             upd_en,
    input  logic [BLK_W-1:0] upd_blk,
    input  logic             upd_store,
    input  logic             kw_en,
    input  logic [BLK_W-1:0] kw_blk,
    input  skey_t            kw_key,
    input  logic [BLK_W-1:0] kr_blk,
    output skey_t            kr_key
);

    skey_t keys [NBLK];

    for (genvar g = 0; g < NBLK; g++) begin : g_blk
        logic hit_w;
        logic hit_u;
        assign hit_w = kw_en  && (kw_blk  == BLK_W'(g));
        assign hit_u = upd_en && (upd_blk == BLK_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                keys[g] <= '0;
            end else if (hit_w) begin
                keys[g] <= kw_key;
            end else if (hit_u) begin
                keys[g].rf <= 1'b1;
                if (upd_store) begin
                    keys[g].ch <= 1'b1;
                end
            end
        end
    end

    assign lk_key = keys[lk_blk];
    assign kr_key = keys[kr_blk];

    AST_KEY_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        kw_en |=> (keys[$past(kw_blk)] == $past(kw_key))) else $error("key write lost"); // R1

    AST_REF_SET: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !(kw_en && kw_blk == upd_blk)) |=> keys[$past(upd_blk)].rf) else $error("ref not set"); // R11

    AST_CHG_SET: assert property (@(posedge clk) disable iff (rst)
        (upd_en && upd_store && !(kw_en && kw_blk == upd_blk)) |=> keys[$past(upd_blk)].ch) else $error("chg not set"); // R11

endmodule

// File: rtl/skp_judge.sv
module skp_judge
    import skp_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int LOW_LIMIT = 2048
) (
    input  logic              clk,
    input  logic              rst,
    input  skey_t             key,
    input  logic [3:0]        ak,
    input  logic              store,
    input  src_e              src,
    input  logic [ADDR_W-1:0] addr,
    input  logic              xlat,
    input  logic              priv,
    input  logic              sp_en,
    input  logic              fp_en,
    output logic              deny,
    output logic              eff_store
);

    logic fits;
    logic checked;
    logic sp_bypass;
    logic low_win;
    logic fp_bypass;

    always_comb begin
        eff_store = store && (src != SRC_IFETCH);
        fits      = key_fits(ak, key.acc);
        checked   = eff_store || key.fp;
        sp_bypass = sp_en && (key.acc == BYPASS_KEY) && is_cpu(src);
        low_win   = (addr < ADDR_W'(LOW_LIMIT));
        fp_bypass = fp_en && !eff_store && low_win
                    && !(xlat && priv) && (src != SRC_MEAS);
        deny      = checked && !fits && !sp_bypass && !fp_bypass;
    end

    AST_ZERO_KEY_PASSES: assert property (@(posedge clk) disable iff (rst)
        (ak == 4'd0) |-> !deny) else $error("zero key denied"); // R2

    AST_UNGUARDED_FETCH: assert property (@(posedge clk) disable iff (rst)
        (!store && !key.fp) |-> !deny) else $error("unguarded fetch denied"); // R3

    AST_IFETCH_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_IFETCH) |-> !eff_store) else $error("ifetch as write"); // R8

endmodule

// File: rtl/skp_report.sv
module skp_report
    import skp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  verdict_t vin,
    output logic     rsp_valid,
    output logic     rsp_grant,
    output logic     rsp_opnd_exc,
    output logic     rsp_if_supp,
    output logic [1:0] rsp_ilc,
    output logic     rsp_chan_pchk,
    output logic     rsp_meas_pchk,
    output logic     rsp_mem_we
);

    logic [3:0] flag_d;
    logic [3:0] flag_q;

    always_comb begin
        flag_d = '0;
        if (vin.valid && vin.deny) begin
            flag_d[vin.src] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_grant  <= 1'b0;
            rsp_mem_we <= 1'b0;
            flag_q     <= '0;
        end else begin
            rsp_valid  <= vin.valid;
            rsp_grant  <= vin.valid && !vin.deny;
            rsp_mem_we <= vin.valid && !vin.deny && vin.store;
            flag_q     <= flag_d;
        end
    end

    assign rsp_opnd_exc  = flag_q[SRC_OPND];
    assign rsp_if_supp   = flag_q[SRC_IFETCH];
    assign rsp_chan_pchk = flag_q[SRC_CHAN];
    assign rsp_meas_pchk = flag_q[SRC_MEAS];
    assign rsp_ilc       = 2'b00;

    AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rsp_opnd_exc, rsp_if_supp, rsp_chan_pchk, rsp_meas_pchk})) else $error("multiple flags"); // R9

    AST_DENY_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_grant) |->
        ($countones({rsp_opnd_exc, rsp_if_supp, rsp_chan_pchk, rsp_meas_pchk}) == 1)) else $error("unflagged deny"); // R7

    AST_WE_ONLY_GRANT: assert property (@(posedge clk) disable iff (rst)
        rsp_mem_we |-> (rsp_valid && rsp_grant)) else $error("write on deny"); // R10

endmodule

// File: rtl/skp_unit.sv
module skp_unit
    import skp_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int LOW_LIMIT = 2048,
    localparam int BLK_W    = ADDR_W - BLK_SHIFT,
    localparam int NBLK     = 1 << BLK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_store,
    input  logic [3:0]        req_key,
    input  logic [1:0]        req_src,
    input  logic              req_xlat,
    input  logic              req_priv,
    input  logic              sp_ovr_en,
    input  logic              fp_ovr_en,
    input  logic              kw_en,
    input  logic [BLK_W-1:0]  kw_blk,
    input  logic [3:0]        kw_acc,
    input  logic              kw_fp,
    input  logic              kw_ref,
    input  logic              kw_chg,
    input  logic [BLK_W-1:0]  kr_blk,
    output logic [3:0]        kr_acc,
    output logic              kr_fp,
    output logic              kr_ref,
    output logic              kr_chg,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic              rsp_opnd_exc,
    output logic              rsp_if_supp,
    output logic [1:0]        rsp_ilc,
    output logic              rsp_chan_pchk,
    output logic              rsp_meas_pchk,
    output logic              rsp_mem_we
);

    logic [BLK_W-1:0] req_blk;
    src_e             src;
    skey_t            cur_key;
    skey_t            new_key;
    skey_t            rd_key;
    logic             deny;
    logic             eff_store;
    verdict_t         verdict;

    assign req_blk = req_addr[ADDR_W-1:BLK_SHIFT];
    assign src     = src_e'(req_src);
    assign new_key = '{acc: kw_acc, fp: kw_fp, rf: kw_ref, ch: kw_chg};

    skp_key_store #(.NBLK(NBLK), .BLK_W(BLK_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .lk_blk    (req_blk),
        .lk_key    (cur_key),
        .upd_en    (req_valid && !deny),
        .upd_blk   (req_blk),
        .upd_store (eff_store),
        .kw_en     (kw_en),
        .kw_blk    (kw_blk),
        .kw_key    (new_key),
        .kr_blk    (kr_blk),
        .kr_key    (rd_key)
    );

    skp_judge #(.ADDR_W(ADDR_W), .LOW_LIMIT(LOW_LIMIT)) u_judge (
        .clk       (clk),
        .rst       (rst),
        .key       (cur_key),
        .ak        (req_key),
        .store     (req_store),
        .src       (src),
        .addr      (req_addr),
        .xlat      (req_xlat),
        .priv      (req_priv),
        .sp_en     (sp_ovr_en),
        .fp_en     (fp_ovr_en),
        .deny      (deny),
        .eff_store (eff_store)
    );

    assign verdict = '{valid: req_valid, deny: deny, store: eff_store, src: src};

    skp_report u_report (
        .clk           (clk),
        .rst           (rst),
        .vin           (verdict),
        .rsp_valid     (rsp_valid),
        .rsp_grant     (rsp_grant),
        .rsp_opnd_exc  (rsp_opnd_exc),
        .rsp_if_supp   (rsp_if_supp),
        .rsp_ilc       (rsp_ilc),
        .rsp_chan_pchk (rsp_chan_pchk),
        .rsp_meas_pchk (rsp_meas_pchk),
        .rsp_mem_we    (rsp_mem_we)
    );

    assign kr_acc = rd_key.acc;
    assign kr_fp  = rd_key.fp;
    assign kr_ref = rd_key.rf;
    assign kr_chg = rd_key.ch;

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid) else $error("missing response"); // R13

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !(rsp_valid || rsp_grant || rsp_mem_we)) else $error("spurious response"); // R13

endmodule

// File: tb/tb_skp_unit.sv
module tb_skp_unit;

    localparam int ADDR_W = 20;
    localparam int BLK_W  = ADDR_W - 12;
    localparam int NB     = 1 << BLK_W;

    logic clk = 1'b0;
    logic rst;
    logic req_valid, req_store, req_xlat, req_priv, sp_ovr_en, fp_ovr_en;
    logic [ADDR_W-1:0] req_addr;
    logic [3:0] req_key;
    logic [1:0] req_src;
    logic kw_en, kw_fp, kw_ref, kw_chg;
    logic [BLK_W-1:0] kw_blk, kr_blk;
    logic [3:0] kw_acc, kr_acc;
    logic kr_fp, kr_ref, kr_chg;
    logic rsp_valid, rsp_grant, rsp_opnd_exc, rsp_if_supp, rsp_chan_pchk, rsp_meas_pchk, rsp_mem_we;
    logic [1:0] rsp_ilc;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [3:0] m_acc [NB];
    logic       m_fp  [NB];
    logic       m_rf  [NB];
    logic       m_ch  [NB];

    always #2 clk = ~clk;

    skp_unit #(.ADDR_W(ADDR_W)) dut (.*);

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit e_deny(input logic [3:0] acc, input logic fp, input logic [3:0] ak,
                                  input logic st, input logic [1:0] s, input logic [ADDR_W-1:0] a,
                                  input logic xl, input logic pv, input logic spe, input logic fpe);
        bit est = st && (s != 2'd1);
        if (ak == 4'd0 || ak == acc) return 0;
        if (!est && !fp) return 0;
        if (spe && acc == 4'd9 && s <= 2'd1) return 0;
        if (fpe && !est && a < 2048 && !(xl && pv) && s != 2'd3) return 0;
        return 1;
    endfunction

    task automatic clear_in();
        req_valid = 0; req_store = 0; req_xlat = 0; req_priv = 0;
        req_addr = '0; req_key = '0; req_src = '0; kw_en = 0;
    endtask

    task automatic model_write(input int b, input logic [3:0] a, input logic f, input logic r, input logic c);
        m_acc[b] = a; m_fp[b] = f; m_rf[b] = r; m_ch[b] = c;
    endtask

    task automatic key_write(input int b, input logic [3:0] a, input logic f, input logic r, input logic c);
        @(negedge clk);
        clear_in();
        kw_en = 1; kw_blk = BLK_W'(b); kw_acc = a; kw_fp = f; kw_ref = r; kw_chg = c;
        @(posedge clk);
        #1;
        model_write(b, a, f, r, c);
    endtask

    task automatic key_read(input int b, input string tag);
        @(negedge clk);
        clear_in();
        kr_blk = BLK_W'(b);
        #1;
        chk(kr_acc, m_acc[b], tag);
        chk(kr_fp, m_fp[b], tag);
        chk(kr_ref, m_rf[b], tag);
        chk(kr_chg, m_ch[b], tag);
    endtask

    // one request, optionally with a colliding key write; compares all outputs
    task automatic do_req(input logic [ADDR_W-1:0] a, input logic st, input logic [3:0] ak,
                          input logic [1:0] s, input logic xl, input logic pv,
                          input bit with_kw, input int wb, input logic [3:0] wa, input logic wf,
                          input string tag);
        int  b = int'(a[ADDR_W-1:12]);
        bit  dn;
        bit  est;
        @(negedge clk);
        clear_in();
        req_valid = 1; req_addr = a; req_store = st; req_key = ak;
        req_src = s; req_xlat = xl; req_priv = pv;
        if (with_kw) begin
            kw_en = 1; kw_blk = BLK_W'(wb); kw_acc = wa; kw_fp = wf; kw_ref = 0; kw_chg = 0;
        end
        dn  = e_deny(m_acc[b], m_fp[b], ak, st, s, a, xl, pv, sp_ovr_en, fp_ovr_en);
        est = st && (s != 2'd1);
        @(posedge clk);
        #1;
        chk(rsp_valid, 1, {tag, " R13 valid"});
        chk(rsp_grant, !dn, {tag, " grant"});
        chk(rsp_opnd_exc, dn && s == 2'd0, {tag, " R7 opnd"});
        chk(rsp_if_supp, dn && s == 2'd1, {tag, " R8 ifsupp"});
        chk(rsp_ilc, 0, {tag, " R8 ilc"});
        chk(rsp_chan_pchk, dn && s == 2'd2, {tag, " R9 chan"});
        chk(rsp_meas_pchk, dn && s == 2'd3, {tag, " R9 meas"});
        chk(rsp_mem_we, !dn && est, {tag, " R10 we"});
        if (!dn) begin
            m_rf[b] = 1;
            if (est) m_ch[b] = 1;
        end
        if (with_kw) model_write(wb, wa, wf, 0, 0);
    endtask

    task automatic idle_check();
        @(negedge clk);
        clear_in();
        @(posedge clk);
        #1;
        chk(rsp_valid, 0, "R13 idle valid");
        chk(rsp_grant, 0, "R13 idle grant");
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7781));
        for (int i = 0; i < NB; i++) model_write(i, 0, 0, 0, 0);
        clear_in();
        kr_blk = '0; kw_blk = '0; kw_acc = '0; kw_fp = 0; kw_ref = 0; kw_chg = 0;
        sp_ovr_en = 0; fp_ovr_en = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        chk(rsp_valid, 0, "R13 reset valid");
        key_read(5, "R1 reset key");

        // R1: maintenance write then read
        key_write(1, 4'd5, 1, 0, 0);
        key_read(1, "R1 write visible");
        chk(kr_acc, 5, "R1 acc literal");

        // R2 / R10 / R11
        do_req(20'h01010, 1, 4'd5, 0, 0, 0, 0, 0, 0, 0, "R2 match store");
        chk(rsp_mem_we, 1, "R10 granted store we");
        key_read(1, "R11 ref chg set");
        chk({kr_ref, kr_chg}, 2'b11, "R11 literal");
        do_req(20'h01020, 1, 4'd3, 0, 0, 0, 0, 0, 0, 0, "R7 mismatch store");
        chk(rsp_opnd_exc, 1, "R7 literal");
        chk(rsp_mem_we, 0, "R10 denied store no we");
        do_req(20'h01020, 1, 4'd0, 2, 0, 0, 0, 0, 0, 0, "R2 zero key");
        chk(rsp_grant, 1, "R2 literal");

        // R3 / R4
        key_write(2, 4'd6, 0, 0, 0);
        do_req(20'h02000, 0, 4'd3, 0, 0, 0, 0, 0, 0, 0, "R3 unguarded fetch");
        chk(rsp_grant, 1, "R3 literal fetch");
        do_req(20'h02000, 1, 4'd3, 0, 0, 0, 0, 0, 0, 0, "R3 store checked");
        chk(rsp_grant, 0, "R3 literal store");
        key_write(2, 4'd6, 1, 0, 0);
        do_req(20'h02004, 0, 4'd3, 0, 0, 0, 0, 0, 0, 0, "R4 guarded fetch");
        chk(rsp_grant, 0, "R4 literal");

        // R5
        key_write(3, 4'd9, 1, 0, 0);
        sp_ovr_en = 1;
        do_req(20'h03000, 1, 4'd3, 0, 0, 0, 0, 0, 0, 0, "R5 cpu bypass");
        chk(rsp_grant, 1, "R5 literal cpu");
        do_req(20'h03000, 1, 4'd3, 2, 0, 0, 0, 0, 0, 0, "R5 chan no bypass");
        chk(rsp_chan_pchk, 1, "R9 literal chan");
        sp_ovr_en = 0;
        do_req(20'h03000, 0, 4'd3, 1, 0, 0, 0, 0, 0, 0, "R5 disabled");
        chk(rsp_grant, 0, "R5 literal off");

        // R6
        key_write(0, 4'd4, 1, 0, 0);
        fp_ovr_en = 1;
        do_req(20'h007FF, 0, 4'd3, 0, 0, 0, 0, 0, 0, 0, "R6 addr 2047");
        chk(rsp_grant, 1, "R6 literal 2047");
        do_req(20'h00800, 0, 4'd3, 0, 0, 0, 0, 0, 0, 0, "R6 addr 2048");
        chk(rsp_grant, 0, "R6 literal 2048");
        do_req(20'h00064, 0, 4'd3, 0, 1, 1, 0, 0, 0, 0, "R6 private");
        chk(rsp_grant, 0, "R6 literal private");
        do_req(20'h00064, 0, 4'd3, 0, 1, 0, 0, 0, 0, 0, "R6 xlat nonprivate");
        chk(rsp_grant, 1, "R6 literal xlat");
        do_req(20'h00064, 0, 4'd3, 3, 0, 0, 0, 0, 0, 0, "R6 meas excluded");
        chk(rsp_meas_pchk, 1, "R9 literal meas");
        do_req(20'h00064, 1, 4'd3, 0, 0, 0, 0, 0, 0, 0, "R6 store not excused");
        chk(rsp_grant, 0, "R6 literal store");
        fp_ovr_en = 0;

        // R8
        do_req(20'h02008, 1, 4'd3, 1, 0, 0, 0, 0, 0, 0, "R8 ifetch store bit");
        chk(rsp_if_supp, 1, "R8 literal supp");
        chk(rsp_mem_we, 0, "R8 no we");

        // R11 denied leaves bits
        key_write(6, 4'd7, 1, 0, 0);
        do_req(20'h06000, 1, 4'd2, 0, 0, 0, 0, 0, 0, 0, "R11 denied");
        key_read(6, "R11 bits untouched");
        chk({kr_ref, kr_chg}, 2'b00, "R11 literal untouched");

        // R12 collision
        do_req(20'h06000, 0, 4'd2, 0, 0, 0, 1, 6, 4'd2, 1, "R12 old key");
        chk(rsp_grant, 0, "R12 literal old key");
        key_read(6, "R12 write wins");
        key_write(7, 4'd8, 0, 0, 0);
        do_req(20'h07000, 1, 4'd8, 0, 0, 0, 1, 7, 4'd8, 1, "R12 write beats ref");
        key_read(7, "R12 ref not kept");
        chk(kr_ref, 0, "R12 literal ref");

        idle_check();

        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [ADDR_W-1:0] a;
            int bsel = $urandom % 4;
            logic [11:0] off = ($urandom % 2 == 0) ? 12'($urandom % 4096) : 12'(1536 + $urandom % 1024);
            a = {BLK_W'(bsel), off};
            sp_ovr_en = ($urandom % 2 == 1);
            fp_ovr_en = ($urandom % 2 == 1);
            if ($urandom % 8 == 0) begin
                int kb = $urandom % 4;
                logic [3:0] ka = ($urandom % 3 == 0) ? 4'd9 : 4'($urandom % 5);
                key_write(kb, ka, 1'($urandom % 2), 0, 0);
            end
            if ($urandom % 10 == 0) begin
                idle_check();
            end else if ($urandom % 12 == 0) begin
                do_req(a, 1'($urandom % 2), 4'($urandom % 5), 2'($urandom % 4),
                       1'($urandom % 2), 1'($urandom % 2), 1, bsel,
                       4'($urandom % 5), 1'($urandom % 2), "R12 random collide");
            end else begin
                do_req(a, 1'($urandom % 2), 4'($urandom % 5), 2'($urandom % 4),
                       1'($urandom % 2), 1'($urandom % 2), 0, 0, 0, 0, "R4 random");
            end
            if ($urandom % 16 == 0) key_read(bsel, "R11 random read");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule